// File: doc/BRIEF.md
# Dual-Rate LED Blink Dimmer

This block drives eight open-drain LED pins from two independent blink generators. Each generator divides a shared clock-enable tick by a programmable 8-bit prescaler. Every prescaler wrap advances an 8-bit duty counter. The generator pulls its LEDs on while that counter is below a programmable 8-bit on-time value. Each LED has a 2-bit source code that picks one of four sources: released (off), held on, generator 0, or generator 1.

Software programs the block through a small synchronous register port with combinational readback. The same port also returns the pad levels through a two-stage synchronizer, so a released pin can serve as a general-purpose input. A new prescaler or on-time value is held in a shadow register. It becomes active only when its generator's duty counter rolls over, so the current blink period always runs to completion.

The tick is expected at 256 times the base blink rate. With a tick rate of 152 × 256 Hz, a generator's period is (prescale + 1) / 152 seconds and its on fraction is ontime / 256.

Top module: `led_blink_dimmer`

## Requirements
- R1: After reset, the readback shows these values: address 1 (prescale 0) = 0xFF, address 2 (on-time 0) = 0x80, address 3 (prescale 1) = 0x00, address 4 (on-time 1) = 0x80, and addresses 5 and 6 (selectors) = 0x00. All `led_drive_low` bits are 0.
- R2: While `rst_n` is low, every register keeps its reset value and writes have no effect. Normal operation starts on the first clock after `rst_n` returns high.
- R3: A generator's duty counter moves only on clocks with `tick` high. It advances by one on every (P+1)-th tick, where P is the active prescale value. It wraps from 255 to 0.
- R4: A generator is on (low) while its duty counter is below its active on-time value D. It is off otherwise. D = 0 keeps the generator off permanently.
- R5: LED i takes its 2-bit code from bits [2k+1:2k], with k = i mod 4, of the selector at address 5 (LEDs 0–3) or address 6 (LEDs 4–7). The codes are: 00 = released (`led_drive_low` = 0), 01 = driven low, 10 = follows generator 0, 11 = follows generator 1. A selector change shows on the outputs one clock after the write.
- R6: A prescale or on-time write reads back at once. The generator uses the new value only from the clock on which its duty counter wraps 255→0 (the last value written before that clock wins).
- R7: Address 0 returns `pad_in` as it stood two clocks earlier. It reads 0xFF straight after reset. Writes to address 0 are ignored.
- R8: Address 7 reads 0 and ignores writes. Register writes use `reg_we`, `reg_addr` and `reg_wdata` and take effect on the next rising clock.
- R9: The two generators keep separate counters and active values. Writing one never disturbs the timing of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, held for the whole reset period |
| tick | input | 1 | Time-base clock enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pad_in | input | 8 | Levels sensed at the LED pads |
| led_drive_low | output | 8 | Open-drain pull-down enable per LED; 0 = released |

## Verification
The bench aims at the moment a shadow value becomes active. It writes a new on-time value in the middle of a period and checks that the old value stays in force until the counter rolls over. A design that applied the value at once would clip the running pulse and diverge within a cycle. On-time values of 0 and 0xFF probe the edges of the comparison: an off-by-one comparator would light the LED at zero, or leave it dark on the last step. A sparse tick pattern catches counters that run without the enable. A long run on generator 0 confirms its first rollover only happens after 65536 ticks, and that generator 1 keeps its own timing meanwhile. A reset held during writes, plus pad reads at the two-clock delay, catch writes that slip through reset and synchronizers with the wrong depth.

// File: rtl/dim_pkg.sv
package dim_pkg;
  localparam int DW    = 8;
  localparam int NLED  = 8;
  localparam int NGEN  = 2;
  localparam int LPR   = 4;            // LEDs per selector register
  localparam int NSEL  = NLED / LPR;
  localparam int AW    = 3;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_LOW = 2'b01,
    SRC_G0  = 2'b10,
    SRC_G1  = 2'b11
  } src_e;

  localparam logic [AW-1:0] A_PIN   = 3'd0;
  localparam logic [AW-1:0] A_PSC0  = 3'd1;
  localparam logic [AW-1:0] A_DUTY0 = 3'd2;
  localparam logic [AW-1:0] A_PSC1  = 3'd3;
  localparam logic [AW-1:0] A_DUTY1 = 3'd4;
  localparam logic [AW-1:0] A_SEL0  = 3'd5;
  localparam logic [AW-1:0] A_SEL1  = 3'd6;

  localparam logic [DW-1:0] RST_PSC0  = 8'hFF;
  localparam logic [DW-1:0] RST_PSC1  = 8'h00;
  localparam logic [DW-1:0] RST_DUTY  = 8'h80;

  // Generator is "on" while its step counter is below the on-time.
  function automatic logic duty_on(input logic [DW-1:0] cnt, input logic [DW-1:0] ontime);
    return cnt < ontime;
  endfunction

  // Pull-down decision for one LED from its code and both generators.
  function automatic logic led_low(input src_e code, input logic g0_on, input logic g1_on);
    case (code)
      SRC_LOW: return 1'b1;
      SRC_G0:  return g0_on;
      SRC_G1:  return g1_on;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int            W        = 8,
  parameter logic [W-1:0]  RST_PSC  = '1,
  parameter logic [W-1:0]  RST_DUTY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] psc_req,
  input  logic [W-1:0] duty_req,
  output logic         gen_on
);
  logic [W-1:0] pre_q, cnt_q, act_psc_q, act_duty_q;
  logic         step_evt, wrap_evt;

  assign step_evt = tick && (pre_q == act_psc_q);
  assign wrap_evt = step_evt && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      cnt_q      <= '0;
      act_psc_q  <= RST_PSC;
      act_duty_q <= RST_DUTY;
    end else if (tick) begin
      if (step_evt) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (wrap_evt) begin
          act_psc_q  <= psc_req;
          act_duty_q <= duty_req;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign gen_on = (W == dim_pkg::DW) ? dim_pkg::duty_on(cnt_q, act_duty_q) : (cnt_q < act_duty_q);

  a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> ($stable(act_duty_q) && $stable(act_psc_q)));
  a_r3_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && $stable(pre_q)));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (cnt_q == $past(cnt_q) + 1'b1) && (pre_q == '0));
  a_r4_zero_never_on: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty_q == '0) |-> !gen_on);
endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_q
);
  logic [W-1:0] mid_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= RST_VAL;
      pad_q <= RST_VAL;
    end else begin
      mid_q <= pad_in;
      pad_q <= mid_q;
    end
  end
endmodule

// File: rtl/led_blink_dimmer.sv
module led_blink_dimmer
  import dim_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [7:0]    pad_in,
  output logic [7:0]    led_drive_low
);
  logic [DW-1:0] psc_q  [NGEN];
  logic [DW-1:0] duty_q [NGEN];
  logic [DW-1:0] sel_q  [NSEL];
  logic [NGEN-1:0] gen_on;
  logic [NLED-1:0] pin_q;

  // Shadow registers written through the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q[0]  <= RST_PSC0;
      psc_q[1]  <= RST_PSC1;
      duty_q[0] <= RST_DUTY;
      duty_q[1] <= RST_DUTY;
      for (int s = 0; s < NSEL; s++) sel_q[s] <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_PSC0:  psc_q[0]  <= reg_wdata;
        A_DUTY0: duty_q[0] <= reg_wdata;
        A_PSC1:  psc_q[1]  <= reg_wdata;
        A_DUTY1: duty_q[1] <= reg_wdata;
        A_SEL0:  sel_q[0]  <= reg_wdata;
        A_SEL1:  sel_q[1]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_PIN:   reg_rdata = pin_q;
      A_PSC0:  reg_rdata = psc_q[0];
      A_DUTY0: reg_rdata = duty_q[0];
      A_PSC1:  reg_rdata = psc_q[1];
      A_DUTY1: reg_rdata = duty_q[1];
      A_SEL0:  reg_rdata = sel_q[0];
      A_SEL1:  reg_rdata = sel_q[1];
      default: reg_rdata = '0;
    endcase
  end

  generate
    for (genvar g = 0; g < NGEN; g++) begin : g_gen
      blink_gen #(
        .W        (DW),
        .RST_PSC  ((g == 0) ? RST_PSC0 : RST_PSC1),
        .RST_DUTY (RST_DUTY)
      ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .psc_req  (psc_q[g]),
        .duty_req (duty_q[g]),
        .gen_on   (gen_on[g])
      );
    end

    for (genvar i = 0; i < NLED; i++) begin : g_led
      src_e code;
      assign code = src_e'(sel_q[i / LPR][2 * (i % LPR) +: 2]);
      assign led_drive_low[i] = led_low(code, gen_on[0], gen_on[1]);

      a_r5_released_code: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SRC_OFF) |-> !led_drive_low[i]);
      a_r5_forced_code: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SRC_LOW) |-> led_drive_low[i]);
    end
  endgenerate

  pad_sync #(.W(NLED), .RST_VAL({NLED{1'b1}})) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .pad_q  (pin_q)
  );

  a_r2_selectors_still_in_reset: assert property (@(posedge clk)
    !rst_n |-> (led_drive_low == '0));
endmodule

// File: tb/sim_led_blink_dimmer.sv
`timescale 1ns/1ps
module sim_led_blink_dimmer;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, pad_in = 8'hFF;
  logic [7:0] reg_rdata, led_drive_low;

  always #4 clk = ~clk;

  led_blink_dimmer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .led_drive_low(led_drive_low)
  );

  // Behavioural reference state
  int m_psc[2], m_duty[2], m_sel[2];
  int m_apsc[2], m_aduty[2], m_pre[2], m_cnt[2];
  int m_s1, m_s2;
  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  task automatic model_reset();
    m_psc[0] = 255; m_psc[1] = 0; m_duty[0] = 128; m_duty[1] = 128;
    m_sel[0] = 0; m_sel[1] = 0;
    for (int g = 0; g < 2; g++) begin
      m_apsc[g] = m_psc[g]; m_aduty[g] = m_duty[g]; m_pre[g] = 0; m_cnt[g] = 0;
    end
    m_s1 = 255; m_s2 = 255;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();   // R2: defaults held
    else begin
      for (int g = 0; g < 2; g++) begin
        if (tick) begin
          if (m_pre[g] >= m_apsc[g]) begin
            m_pre[g] = 0;
            if (m_cnt[g] == 255) begin   // R6: shadow takes effect at rollover
              m_cnt[g] = 0; m_apsc[g] = m_psc[g]; m_aduty[g] = m_duty[g];
            end else m_cnt[g] = m_cnt[g] + 1;
          end else m_pre[g] = m_pre[g] + 1;
        end
      end
      m_s2 = m_s1; m_s1 = int'(pad_in);
      if (reg_we) begin
        case (reg_addr)
          3'd1: m_psc[0] = reg_wdata;  3'd2: m_duty[0] = reg_wdata;
          3'd3: m_psc[1] = reg_wdata;  3'd4: m_duty[1] = reg_wdata;
          3'd5: m_sel[0] = reg_wdata;  3'd6: m_sel[1] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_drive();
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      int code = (m_sel[i / 4] >> (2 * (i % 4))) & 3;
      bit on0 = m_cnt[0] < m_aduty[0];
      bit on1 = m_cnt[1] < m_aduty[1];
      bit lo = (code == 1) || (code == 2 && on0) || (code == 3 && on1);
      if (lo) r = r | (1 << i);
    end
    return r;
  endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return m_s2;
      1: return m_psc[0]; 2: return m_duty[0];
      3: return m_psc[1]; 4: return m_duty[1];
      5: return m_sel[0]; 6: return m_sel[1];
      default: return 0;   // R8
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (int'(led_drive_low) != exp_drive()) begin
      fails++;
      $display("FAIL %s led_drive_low actual=%02h expected=%02h t=%0t", req, led_drive_low, exp_drive(), $time);
    end
    checks++;
    if (int'(reg_rdata) != exp_read(int'(reg_addr))) begin
      fails++;
      $display("FAIL %s reg_rdata[%0d] actual=%02h expected=%02h t=%0t", req, reg_addr, reg_rdata, exp_read(int'(reg_addr)), $time);
    end
  endtask

  // One cycle: drive at negedge, check shortly after
  task automatic step(bit we, int a, int d, bit tk);
    @(negedge clk);
    reg_we = we; reg_addr = a[2:0]; reg_wdata = d[7:0]; tick = tk;
    #1 compare();
  endtask

  task automatic wr(int a, int d);
    step(1, a, d, 1);
  endtask

  task automatic run(int n, int period, int a);
    for (int k = 0; k < n; k++) step(0, a, 0, (k % period) == 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 / R2: reset state and writes ignored while reset held
    req = "R2";
    for (int a = 0; a < 8; a++) step(1, a, 8'h5A, 1);
    @(negedge clk); rst_n = 1;
    req = "R1";
    for (int a = 0; a < 8; a++) step(0, a, 0, 0);

    // R5: mixed codes on both selectors
    req = "R5";
    wr(5, 8'h39);          // LED0=01 LED1=10 LED2=11 LED3=00
    wr(6, 8'h1F);          // LED4=11 LED5=11 LED6=01 LED7=00
    run(600, 1, 5);

    // R4 / R6: on-time 0 written mid-period, active only after rollover
    req = "R6";
    run(37, 1, 4);
    wr(4, 8'h00);
    run(400, 1, 4);
    req = "R4";
    wr(4, 8'hFF);
    run(600, 1, 4);
    wr(4, 8'h01);
    run(300, 1, 4);

    // R3: prescale 2 and a sparse tick
    req = "R3";
    wr(3, 8'h02);
    wr(4, 8'h40);
    run(1700, 1, 3);
    run(2400, 3, 3);
    run(50, 1000, 3);

    // R7: pad sampling through two stages, write to address 0 ignored
    req = "R7";
    pad_in = 8'hA5; run(3, 1, 0);
    pad_in = 8'h3C; step(1, 0, 8'h00, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    pad_in = 8'h00; run(4, 1, 0);
    pad_in = 8'hFF; run(4, 1, 0);

    // R8: unused address
    req = "R8";
    step(1, 7, 8'hC3, 1);
    run(3, 1, 7);

    // R9 / R6: generator 0 rollover after a full default period while generator 1 runs
    req = "R9";
    wr(1, 8'h00);
    wr(2, 8'h40);
    wr(4, 8'hC0);
    run(66000, 1, 2);
    run(800, 1, 1);

    // R2: reset asserted mid-run with write attempts, then back to defaults (R1)
    req = "R2";
    @(negedge clk); rst_n = 0;
    for (int a = 0; a < 8; a++) step(1, a, 8'h11, 1);
    @(negedge clk); rst_n = 1;
    req = "R1";
    for (int a = 0; a < 8; a++) step(0, a, 0, 0);
    wr(5, 8'hAA);
    run(300, 1, 5);

    finish_run();
  end
endmodule